// File: doc/BRIEF.md
# Pending Interrupt Status Register

This block holds the pending-interrupt flags of a small processor core. Six sources feed it: a serial port, a parallel/host port, a debug port, two external interrupt pins and a timer. Each source sets its flag when it signals an event, whether or not the matching bit of the enable mask is set. Software can therefore poll the status word for conditions it has chosen not to take as vectored interrupts. The block also drives one request line to the core. That line is high when some pending flag is enabled in the mask and the core is not already at interrupt level.

Flags are cleared in one of three ways, and the source fixes which. The serial and parallel/host flags clear when their data register is accessed. The debug flag clears when its data register is read. The timer and external-pin flags clear either when software writes a one to them or when the core returns from interrupt. When the core enters interrupt level (the rising edge of the acknowledge input), the block takes a snapshot of these return-clearable flags. While the core stays at that level, the status word shows the snapshot and not the live flags. The return strobe clears only the flags that were captured in the snapshot.

Top module: `intr_status_reg`

## Requirements
- R1: Reset clears every status flag and every mask bit, and holds the request output low.
- R2: An event pulse sets its flag in the status word after one clock, regardless of the mask. The flag positions are: serial bit 0, parallel/host bit 1, debug bit 4, external pin 0 bit 6, external pin 1 bit 7, timer bit 8. All other status bits always read zero.
- R3: A status write clears each timer or external-pin flag whose data bit is one. Zero data bits have no effect, and one bits at the positions of serial, parallel/host or debug have no effect.
- R4: A return strobe clears the timer and external-pin flags that were captured at the last entry to interrupt level. Flags raised after that capture stay set.
- R5: A serial data access clears the serial flag, and a parallel/host data access clears the parallel/host flag. Neither affects any other flag.
- R6: A debug data read clears the debug flag and no other flag.
- R7: If an event and a clear for the same flag arrive in the same cycle, the flag is set after that cycle.
- R8: While at interrupt level, the timer and external-pin bits of the status word show the values captured at the rising edge of the acknowledge input. Events raised during that time do not appear until the level drops.
- R9: The request output is high exactly when the AND of the pending flags and the mask is non-zero and the acknowledge input is low.
- R10: A mask write loads all 16 mask bits, and the new value reads back on the mask output after one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_evt | input | 1 | Serial port event pulse |
| par_evt | input | 1 | Parallel/host port event pulse |
| dbg_evt | input | 1 | Debug port event pulse |
| tmr_evt | input | 1 | Timer timeout pulse |
| ext_evt | input | 2 | External pin event pulses |
| ser_acc | input | 1 | Serial data register accessed |
| par_acc | input | 1 | Parallel/host data register accessed |
| dbg_rd | input | 1 | Debug data register read |
| stat_we | input | 1 | Status write strobe (write one to clear) |
| stat_wdata | input | 16 | Status write data |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 16 | Mask write data |
| int_level | input | 1 | Interrupt acknowledge: core at interrupt level |
| ret_pulse | input | 1 | Return-from-interrupt strobe |
| stat_rdata | output | 16 | Status word seen by software |
| mask_rdata | output | 16 | Current mask |
| irq | output | 1 | Masked interrupt request to the core |

## Verification
Every flag and the mask are held in a single register stage. A stimulus driven before a rising edge therefore shows on the status or mask output right after that edge. The request output is combinational from the registered flags, the mask and the acknowledge input, so it responds to the acknowledge input in the same cycle. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. The snapshot case needs two edges: one edge after the acknowledge rises, and a further edge for the event that must stay hidden.

// File: rtl/isr_pkg.sv
package isr_pkg;
    localparam int STAT_W = 16;
    localparam int NSRC   = 6;

    typedef enum logic [2:0] {
        SRC_SER  = 3'd0,
        SRC_PAR  = 3'd1,
        SRC_DBG  = 3'd2,
        SRC_EXT0 = 3'd3,
        SRC_EXT1 = 3'd4,
        SRC_TMR  = 3'd5
    } src_e;

    // Timer position is fixed by software convention (mask 0x0100).
    function automatic int src_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            2:       return 4;
            3:       return 6;
            4:       return 7;
            default: return 8;
        endcase
    endfunction

    // Return-clearable sources: both pins and the timer.
    function automatic bit src_ret(input int idx);
        return idx >= int'(SRC_EXT0);
    endfunction

    function automatic logic [STAT_W-1:0] used_mask();
        logic [STAT_W-1:0] m;
        m = '0;
        for (int i = 0; i < NSRC; i++) m[src_pos(i)] = 1'b1;
        return m;
    endfunction

    function automatic logic [STAT_W-1:0] ret_mask();
        logic [STAT_W-1:0] m;
        m = '0;
        for (int i = 0; i < NSRC; i++) if (src_ret(i)) m[src_pos(i)] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/isr_flag.sv
module isr_flag #(
    parameter bit RET_CLR = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic acc_clr,
    input  logic w1c,
    input  logic ret,
    input  logic capture,
    input  logic show,
    output logic pend,
    output logic view
);
    logic snap;
    logic clr;

    always_comb clr = RET_CLR ? (w1c | (ret & snap)) : acc_clr;

    always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else     pend <= set | (pend & ~clr);
    end

    always_ff @(posedge clk) begin
        if (rst)                     snap <= 1'b0;
        else if (capture && RET_CLR) snap <= pend;
        else if (ret || w1c)         snap <= 1'b0;
    end

    always_comb view = (RET_CLR && show) ? snap : pend;

    // R7: an event always leaves the flag set
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        set |=> pend);
    // R5: an access clear drops an access-cleared flag
    p_acc_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (!RET_CLR && acc_clr && !set) |=> !pend);
    // R3: write one clears a return-clearable flag
    p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
        (RET_CLR && w1c && !set) |=> !pend);
    // R3: with no event and no clear source the flag holds
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!set && !acc_clr && !w1c && !ret) |=> $stable(pend));
    // R8: at interrupt level the shown value is frozen unless cleared
    p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (RET_CLR && show && !ret && !w1c) |=> (!show || $stable(view)));
endmodule

// File: rtl/isr_req.sv
module isr_req #(
    parameter int W = isr_pkg::STAT_W
) (
    input  logic [W-1:0] pend,
    input  logic [W-1:0] mask,
    input  logic         int_level,
    output logic         irq
);
    always_comb irq = (|(pend & mask)) & ~int_level;
endmodule

// File: rtl/intr_status_reg.sv
module intr_status_reg
    import isr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_evt,
    input  logic              par_evt,
    input  logic              dbg_evt,
    input  logic              tmr_evt,
    input  logic [1:0]        ext_evt,
    input  logic              ser_acc,
    input  logic              par_acc,
    input  logic              dbg_rd,
    input  logic              stat_we,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic              int_level,
    input  logic              ret_pulse,
    output logic [STAT_W-1:0] stat_rdata,
    output logic [STAT_W-1:0] mask_rdata,
    output logic              irq
);
    localparam logic [STAT_W-1:0] USED = used_mask();
    localparam logic [STAT_W-1:0] RETM = ret_mask();

    logic [NSRC-1:0]   set_v, acc_v, pend_s, view_s;
    logic [STAT_W-1:0] pend_vec, view_vec, mask_q;
    logic              ack_q, capture;
    logic              unused_wbits;

    always_comb begin
        set_v = '0;
        acc_v = '0;
        set_v[SRC_SER]  = ser_evt;
        set_v[SRC_PAR]  = par_evt;
        set_v[SRC_DBG]  = dbg_evt;
        set_v[SRC_EXT0] = ext_evt[0];
        set_v[SRC_EXT1] = ext_evt[1];
        set_v[SRC_TMR]  = tmr_evt;
        acc_v[SRC_SER]  = ser_acc;
        acc_v[SRC_PAR]  = par_acc;
        acc_v[SRC_DBG]  = dbg_rd;
    end

    assign unused_wbits = ^(stat_wdata & ~RETM);

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= int_level;
    end
    always_comb capture = int_level & ~ack_q;

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int P = src_pos(i);
        isr_flag #(.RET_CLR(src_ret(i))) u_flag (
            .clk     (clk),
            .rst     (rst),
            .set     (set_v[i]),
            .acc_clr (acc_v[i]),
            .w1c     (stat_we & stat_wdata[P]),
            .ret     (ret_pulse),
            .capture (capture),
            .show    (ack_q),
            .pend    (pend_s[i]),
            .view    (view_s[i])
        );
    end

    always_comb begin
        pend_vec = '0;
        view_vec = '0;
        for (int i = 0; i < NSRC; i++) begin
            pend_vec[src_pos(i)] = pend_s[i];
            view_vec[src_pos(i)] = view_s[i];
        end
    end

    isr_req #(.W(STAT_W)) u_req (
        .pend      (pend_vec),
        .mask      (mask_q),
        .int_level (int_level),
        .irq       (irq)
    );

    assign stat_rdata = view_vec;
    assign mask_rdata = mask_q;

    // R1: state is clear the cycle after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (stat_rdata == '0 && mask_rdata == '0 && !irq));
    // R2: unassigned status bits never read as one
    p_unused_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (stat_rdata & ~USED) == '0);
    // R9: no request while the core is at interrupt level
    p_no_req_at_level_r9: assert property (@(posedge clk) disable iff (rst)
        int_level |-> !irq);
    // R10: mask write lands on the next cycle
    p_mask_load_r10: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (mask_rdata == $past(mask_wdata)));
endmodule

// File: tb/intr_status_reg_tb.sv
`timescale 1ns/1ps
module intr_status_reg_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        ser_evt, par_evt, dbg_evt, tmr_evt;
    logic [1:0]  ext_evt;
    logic        ser_acc, par_acc, dbg_rd;
    logic        stat_we, mask_we;
    logic [15:0] stat_wdata, mask_wdata;
    logic        int_level, ret_pulse;
    logic [15:0] stat_rdata, mask_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    intr_status_reg u_dut (
        .clk(clk), .rst(rst),
        .ser_evt(ser_evt), .par_evt(par_evt), .dbg_evt(dbg_evt),
        .tmr_evt(tmr_evt), .ext_evt(ext_evt),
        .ser_acc(ser_acc), .par_acc(par_acc), .dbg_rd(dbg_rd),
        .stat_we(stat_we), .stat_wdata(stat_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .int_level(int_level), .ret_pulse(ret_pulse),
        .stat_rdata(stat_rdata), .mask_rdata(mask_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic idle();
        ser_evt = 0; par_evt = 0; dbg_evt = 0; tmr_evt = 0; ext_evt = 0;
        ser_acc = 0; par_acc = 0; dbg_rd = 0;
        stat_we = 0; stat_wdata = 0; mask_we = 0; mask_wdata = 0;
        ret_pulse = 0;
    endtask

    // inputs already driven at a falling edge; one rising edge, sample at next fall
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle(); int_level = 0; rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 status", stat_rdata, 16'h0000);
        chk("R1 mask", mask_rdata, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_events();
        ser_evt = 1; par_evt = 1; dbg_evt = 1; tmr_evt = 1; ext_evt = 2'b11;
        step();
        chk("R2 all events masked", stat_rdata, 16'h01D3);
        chk("R9 irq with zero mask", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_w1c();
        stat_we = 1; stat_wdata = 16'h0000; step();
        chk("R3 zero write", stat_rdata, 16'h01D3);
        stat_we = 1; stat_wdata = 16'h0013; step();
        chk("R3 write to access bits", stat_rdata, 16'h01D3);
        stat_we = 1; stat_wdata = 16'h0100; step();
        chk("R3 clear timer", stat_rdata, 16'h00D3);
    endtask

    task automatic t_access();
        ser_acc = 1; step();
        chk("R5 serial access", stat_rdata, 16'h00D2);
        par_acc = 1; step();
        chk("R5 parallel access", stat_rdata, 16'h00D0);
        dbg_rd = 1; step();
        chk("R6 debug read", stat_rdata, 16'h00C0);
    endtask

    task automatic t_mask_req();
        mask_we = 1; mask_wdata = 16'h0040; step();
        chk("R10 mask readback", mask_rdata, 16'h0040);
        chk("R9 irq enabled pending", {15'd0, irq}, 16'h0001);
        int_level = 1; #1;
        chk("R9 irq at level", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_snapshot();
        step(); // edge where the acknowledge rise is captured
        tmr_evt = 1; step();
        chk("R8 timer hidden at level", stat_rdata, 16'h00C0);
        ret_pulse = 1; int_level = 0; step();
        chk("R4 return clears captured", stat_rdata, 16'h0100);
        chk("R9 irq timer unmasked", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_collide();
        ext_evt = 2'b01; stat_we = 1; stat_wdata = 16'h0040; step();
        chk("R7 event beats w1c", stat_rdata, 16'h0140);
        chk("R9 irq after collide", {15'd0, irq}, 16'h0001);
        ser_evt = 1; ser_acc = 1; step();
        chk("R7 event beats access", stat_rdata, 16'h0141);
    endtask

    initial begin
        idle(); int_level = 0; rst = 1;
        t_reset();
        t_events();
        t_w1c();
        t_access();
        t_mask_req();
        t_snapshot();
        t_collide();
        t_reset();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x0000 expected=0x0001");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule